// File: doc/BRIEF.md
# Bias-Tracking Delay Calibration Controller

This controller keeps a sampling flip-flop balanced on its metastable point. It does this by watching the raw single-bit stream that the flip-flop produces. Raw samples arrive with a valid strobe. The block groups the valid samples into windows of fixed length and counts the ones in each window. When a window closes, the ones-count falls into one of five bands, and each band applies its own signed correction to a binary tuning counter.

The tuning counter is split into two fields. The upper field sets the number of enabled stages in a coarse delay chain, and the lower field does the same for a fine chain. Each field drives its chain as a thermometer code, so a value k enables the first k stages. A field value larger than its chain has stages is clamped to the chain length. After reset the counter holds a programmed start value, and the windowed feedback then walks it toward a 50% ratio of ones.

Top module: `bias_cal_ctrl`

## Requirements
- R1: Only a completed window of WIN_LEN (default 200) valid samples changes `tune_value`. The change lands on the clock edge that accepts the last sample of the window, and `tune_value` does not move while a window is still filling.
- R2: A cycle with `raw_valid` low is not counted as a sample, whatever the level of `raw_bit`.
- R3: A window whose ones-count is at least 80% of WIN_LEN (160 or more by default) adds 3. A window at 20% or below (40 or fewer) subtracts 3.
- R4: A ones-count strictly between 52% and 80% (105 to 159) adds 1. A ones-count strictly between 20% and 48% (41 to 95) subtracts 1.
- R5: A ones-count from 48% to 52% inclusive (96 to 104) leaves `tune_value` unchanged.
- R6: The counter saturates. A step that would go below 0 gives 0, and a step that would go above 2^(COARSE_BITS+FINE_BITS)-1 (4095 by default) gives that maximum. It never wraps.
- R7: `coarse_sel` has exactly its lowest k bits set, where k is the smaller of `tune_value[11:6]` and COARSE_STAGES (60).
- R8: `fine_sel` has exactly its lowest k bits set, where k is the smaller of `tune_value[5:0]` and FINE_STAGES (50).
- R9: While `rst_n` is low, `tune_value` is held at INIT_VALUE and the window's counts are cleared.
- R10: The window's counts clear on the same edge that applies the adjustment. A window that follows directly on another starts with the next valid sample, so no sample is dropped and none is counted twice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_bit | input | 1 | Raw bit from the metastable sampler |
| raw_valid | input | 1 | Qualifies `raw_bit` for this cycle |
| coarse_sel | output | COARSE_STAGES (60) | Thermometer enables for the coarse delay chain |
| fine_sel | output | FINE_STAGES (50) | Thermometer enables for the fine delay chain |
| tune_value | output | COARSE_BITS+FINE_BITS (12) | Current tuning counter |

## Verification
The bench places windows on every band edge: 160/159, 105/104, 96/95 and 41/40. A comparison that is off by one moves one of these windows into the neighbouring band, and the counter then takes a step of the wrong size. Two instances are driven at the same time, one near zero and one near full scale. A saturation bug shows up as a large jump from wrap-around. Invalid cycles carrying a one are mixed into the sample stream, so a design that counts them gets a wrong band or closes its window early. Windows run back to back with their ones at the tail, so a design that leaks the closing sample into the next window turns a -3 window into a -1 window. A field value of 63 checks that both thermometers clamp to their chain lengths instead of indexing past them.

// File: rtl/bias_cal_pkg.sv
package bias_cal_pkg;

  // Signed correction for one window, from its ones-count.
  // Edges: >=80% strong up, >52% weak up, >=48% hold, >20% weak down, else strong down.
  function automatic logic signed [2:0] band_step(input int ones, input int win);
    int pct100;
    pct100 = ones * 100;
    if (pct100 >= win * 80)      return 3'sd3;
    else if (pct100 > win * 52)  return 3'sd1;
    else if (pct100 >= win * 48) return 3'sd0;
    else if (pct100 > win * 20)  return -3'sd1;
    else                         return -3'sd3;
  endfunction

  // Add a signed step to a counter value and clamp the result to [0, maxv].
  function automatic int sat_step(input int cur, input int step, input int maxv);
    int nxt;
    nxt = cur + step;
    if (nxt < 0)    return 0;
    if (nxt > maxv) return maxv;
    return nxt;
  endfunction

endpackage

// File: rtl/bias_window.sv
module bias_window #(
  parameter int WIN_LEN = 200,
  parameter int WW      = $clog2(WIN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raw_bit,
  input  logic          raw_valid,
  output logic          win_done,
  output logic [WW-1:0] win_ones
);
  logic [WW-1:0] sample_cnt;
  logic [WW-1:0] ones_cnt;

  // The window closes on the cycle that carries its last valid sample.
  assign win_done = raw_valid && (sample_cnt == WW'(WIN_LEN - 1));
  assign win_ones = ones_cnt + WW'(raw_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_cnt <= '0;
      ones_cnt   <= '0;
    end else if (raw_valid) begin
      if (win_done) begin
        sample_cnt <= '0;
        ones_cnt   <= '0;
      end else begin
        sample_cnt <= sample_cnt + 1'b1;
        ones_cnt   <= ones_cnt + WW'(raw_bit);
      end
    end
  end

  p_ones_within_samples_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ones_cnt <= sample_cnt);
  p_window_length_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sample_cnt < WW'(WIN_LEN));
  p_idle_holds_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_valid |=> $stable(sample_cnt) && $stable(ones_cnt));
endmodule

// File: rtl/bias_stepper.sv
module bias_stepper
  import bias_cal_pkg::*;
#(
  parameter int WIN_LEN    = 200,
  parameter int WW         = $clog2(WIN_LEN + 1),
  parameter int CW         = 12,
  parameter int INIT_VALUE = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_done,
  input  logic [WW-1:0] win_ones,
  output logic [CW-1:0] tune
);
  localparam int CMAX = (1 << CW) - 1;

  logic signed [2:0] step;
  logic [CW-1:0]     tune_nxt;

  assign step     = band_step(int'(win_ones), WIN_LEN);
  assign tune_nxt = CW'(sat_step(int'(tune), int'(step), CMAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tune <= CW'(INIT_VALUE);
    else if (win_done) tune <= tune_nxt;
  end

  p_hold_between_windows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !win_done |=> $stable(tune));
  p_step_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> (int'(tune) - int'($past(tune)) <= 3) && (int'($past(tune)) - int'(tune) <= 3));
  p_no_wrap_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && step > 0) |=> tune >= $past(tune));
  p_no_wrap_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && step < 0) |=> tune <= $past(tune));
  p_balanced_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && int'(win_ones) * 100 >= WIN_LEN * 48 && int'(win_ones) * 100 <= WIN_LEN * 52)
      |=> $stable(tune));
endmodule

// File: rtl/therm_decoder.sv
module therm_decoder #(
  parameter int STAGES = 50,
  parameter int VW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VW-1:0]     val,
  output logic [STAGES-1:0] sel
);
  // Each line compares against its own index, so values past STAGES clamp.
  for (genvar i = 0; i < STAGES; i++) begin : g_line
    assign sel[i] = int'(val) > i;
  end

  // Thermometer shape (no holes) and population equal to the clamped value; R7 and R8.
  p_therm_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel + 1'b1) & sel) == '0);
  p_therm_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel) == ((int'(val) > STAGES) ? STAGES : int'(val)));
endmodule

// File: rtl/bias_cal_ctrl.sv
module bias_cal_ctrl #(
  parameter int WIN_LEN       = 200,
  parameter int COARSE_BITS   = 6,
  parameter int FINE_BITS     = 6,
  parameter int COARSE_STAGES = 60,
  parameter int FINE_STAGES   = 50,
  parameter int INIT_VALUE    = 512
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               raw_bit,
  input  logic                               raw_valid,
  output logic [COARSE_STAGES-1:0]           coarse_sel,
  output logic [FINE_STAGES-1:0]             fine_sel,
  output logic [COARSE_BITS+FINE_BITS-1:0]   tune_value
);
  localparam int CW = COARSE_BITS + FINE_BITS;
  localparam int WW = $clog2(WIN_LEN + 1);

  logic          win_done;
  logic [WW-1:0] win_ones;

  bias_window #(.WIN_LEN(WIN_LEN), .WW(WW)) u_window (
    .clk(clk), .rst_n(rst_n), .raw_bit(raw_bit), .raw_valid(raw_valid),
    .win_done(win_done), .win_ones(win_ones)
  );

  bias_stepper #(.WIN_LEN(WIN_LEN), .WW(WW), .CW(CW), .INIT_VALUE(INIT_VALUE)) u_stepper (
    .clk(clk), .rst_n(rst_n), .win_done(win_done), .win_ones(win_ones), .tune(tune_value)
  );

  therm_decoder #(.STAGES(COARSE_STAGES), .VW(COARSE_BITS)) u_coarse (
    .clk(clk), .rst_n(rst_n), .val(tune_value[CW-1:FINE_BITS]), .sel(coarse_sel)
  );

  therm_decoder #(.STAGES(FINE_STAGES), .VW(FINE_BITS)) u_fine (
    .clk(clk), .rst_n(rst_n), .val(tune_value[FINE_BITS-1:0]), .sel(fine_sel)
  );
endmodule

// File: tb/bias_cal_ctrl_bench.sv
module bias_cal_ctrl_bench;
  localparam int WIN  = 200;
  localparam int CMAX = 4095;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw_bit = 1'b0;
  logic raw_valid = 1'b0;
  logic [59:0] lo_coarse, hi_coarse;
  logic [49:0] lo_fine, hi_fine;
  logic [11:0] lo_tune, hi_tune;

  int n_checks = 0;
  int n_fail = 0;
  int exp_lo = 7;
  int exp_hi = 4093;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bias_cal_ctrl #(.INIT_VALUE(7)) u_bias_cal_ctrl (
    .clk(clk), .rst_n(rst_n), .raw_bit(raw_bit), .raw_valid(raw_valid),
    .coarse_sel(lo_coarse), .fine_sel(lo_fine), .tune_value(lo_tune)
  );

  bias_cal_ctrl #(.INIT_VALUE(4093)) u_bias_cal_ctrl_hi (
    .clk(clk), .rst_n(rst_n), .raw_bit(raw_bit), .raw_valid(raw_valid),
    .coarse_sel(hi_coarse), .fine_sel(hi_fine), .tune_value(hi_tune)
  );

  // Band rule restated as plain count thresholds for a 200-sample window.
  function automatic int model_delta(input int ones);
    if (ones >= 160) return 3;
    if (ones >= 105) return 1;
    if (ones >= 96)  return 0;
    if (ones >= 41)  return -1;
    return -3;
  endfunction

  function automatic int clamp_tune(input int v);
    return (v < 0) ? 0 : ((v > CMAX) ? CMAX : v);
  endfunction

  function automatic logic [63:0] therm_ref(input int k, input int lines);
    logic [63:0] r;
    int kk;
    r = '0;
    kk = (k > lines) ? lines : k;
    for (int i = 0; i < kk; i++) r[i] = 1'b1;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [63:0] ec, ef;
    chk(int'(lo_tune) == exp_lo, req, 64'(lo_tune), 64'(exp_lo));
    chk(int'(hi_tune) == exp_hi, req, 64'(hi_tune), 64'(exp_hi));
    ec = therm_ref(exp_lo / 64, 60);
    ef = therm_ref(exp_lo % 64, 50);
    chk(64'(lo_coarse) == ec, "R7", 64'(lo_coarse), ec);
    chk(64'(lo_fine) == ef, "R8", 64'(lo_fine), ef);
    ec = therm_ref(exp_hi / 64, 60);
    ef = therm_ref(exp_hi % 64, 50);
    chk(64'(hi_coarse) == ec, "R7", 64'(hi_coarse), ec);
    chk(64'(hi_fine) == ef, "R8", 64'(hi_fine), ef);
  endtask

  task automatic drive(input logic b, input logic v);
    @(negedge clk);
    raw_bit = b;
    raw_valid = v;
  endtask

  // One window with its ones at the tail; idle cycles carrying a one if gaps set (R2).
  task automatic run_window(input int ones, input bit gaps, input string req);
    for (int i = 0; i < WIN; i++) begin
      if (gaps && (i % 7 == 3)) drive(1'b1, 1'b0);
      if (i == WIN - 1) begin
        @(negedge clk);
        raw_valid = 1'b0;
        chk(int'(lo_tune) == exp_lo, "R1", 64'(lo_tune), 64'(exp_lo));
      end
      drive((i >= WIN - ones) ? 1'b1 : 1'b0, 1'b1);
    end
    @(negedge clk);
    raw_valid = 1'b0;
    raw_bit = 1'b0;
    exp_lo = clamp_tune(exp_lo + model_delta(ones));
    exp_hi = clamp_tune(exp_hi + model_delta(ones));
    check_all(req);
  endtask

  // Back-to-back windows with no idle cycle between them (R10).
  task automatic run_pair(input int ones_a, input int ones_b);
    for (int w = 0; w < 2; w++) begin
      int ones;
      ones = (w == 0) ? ones_a : ones_b;
      for (int i = 0; i < WIN; i++) drive((i >= WIN - ones) ? 1'b1 : 1'b0, 1'b1);
      exp_lo = clamp_tune(exp_lo + model_delta(ones));
      exp_hi = clamp_tune(exp_hi + model_delta(ones));
    end
    @(negedge clk);
    raw_valid = 1'b0;
    raw_bit = 1'b0;
    check_all("R10");
  endtask

  task automatic t_reset;
    raw_valid = 1'b1;
    raw_bit = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check_all("R9");
    raw_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R9");
  endtask

  task automatic t_hold_band;
    run_window(104, 1'b0, "R5");
    run_window(96, 1'b1, "R5");
  endtask

  task automatic t_strong_and_weak;
    run_window(160, 1'b0, "R3");
    run_window(159, 1'b1, "R4");
    run_window(105, 1'b0, "R4");
    run_window(95, 1'b1, "R4");
    run_window(41, 1'b0, "R4");
    run_window(40, 1'b1, "R3");
  endtask

  task automatic t_floor;
    run_window(0, 1'b0, "R6");
    run_window(0, 1'b0, "R6");
    run_window(0, 1'b1, "R6");
    run_window(50, 1'b0, "R6");
  endtask

  task automatic t_climb;
    for (int k = 0; k < 24; k++) run_window(200, (k % 2) == 1, "R3");
    run_window(180, 1'b1, "R7");
  endtask

  task automatic t_boundary_pairs;
    run_pair(200, 40);
    run_pair(160, 0);
  endtask

  task automatic t_full_scale;
    // Push the high instance to 4095, where both fields read 63 and must clamp (R7, R8).
    run_window(200, 1'b0, "R6");
    run_window(200, 1'b0, "R6");
    chk(hi_tune == 12'hfff, "R6", 64'(hi_tune), 64'hfff);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_hold_band();
    t_strong_and_weak();
    t_floor();
    t_climb();
    t_boundary_pairs();
    t_full_scale();
    done = 1'b1;
    finish_run();
  end
endmodule